// File: doc/BRIEF.md
# DS3 Overhead Insertion Controller

This block sits on the system side of a DS3 framer and drives the framer's transmit overhead input port. The framer issues two signals. One is an overhead-enable strobe, which is high for one line-clock period just before the framer handles an overhead bit. The other is a frame-start flag, which accompanies the strobe for the first overhead bit (X) of each M-frame. The controller samples both signals on the falling edge of the 44.736 MHz line clock.

The block does not count line bits. It counts enable strobes from the last strobe that came with the frame flag. From that count it knows which of the 56 overhead positions comes next: 7 subframes of 8 bits, and index 0 is the first X bit. A per-position mask selects which positions the user wants to override. A matching value vector supplies each replacement bit. For a masked position, the block raises an insert request and drives the data bit for one full clock period. A strobe count that runs past the last position without a new frame flag means the framer and the controller disagree. In that case the block drops sync and stays quiet until the next frame-aligned strobe.

Top module: `ds3oh_insert_ctrl`

## Requirements
- R1: While reset is high, at the next falling clock edge the insert request, the data bit, the slot index and the sync flag all go to 0.
- R2: An enable strobe sampled together with the frame flag sets the slot index to 0 and the sync flag to 1 at that falling edge.
- R3: An enable strobe sampled without the frame flag while synced and below index 55 raises the slot index by exactly one.
- R4: Mask bit i belongs to slot i. After a strobe that leaves the block synced at slot i with mask bit i set, the insert request is high for exactly one clock period. In every other case it is low.
- R5: While the insert request is high, the data bit equals bit i of the value vector sampled at that strobe. While the request is low, the data bit is 0.
- R6: While not synced, an enable strobe without the frame flag changes neither the index nor the sync flag, and produces no insert request.
- R7: An enable strobe without the frame flag at index 55 clears the sync flag, returns the index to 0 and produces no insert request.
- R8: A frame flag sampled high while the enable input is low leaves the index, the sync flag and the insert request unchanged.
- R9: A frame-aligned strobe that arrives while the block is synced at a nonzero index moves the index back to 0 and keeps sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Transmit line clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| oh_en_i | input | 1 | One-period strobe that announces the next overhead bit |
| oh_frame_i | input | 1 | Frame-start flag; counts only together with oh_en_i |
| ins_mask_i | input | 56 | Per-slot insertion enable, bit i for slot i |
| ins_value_i | input | 56 | Per-slot replacement bit, bit i for slot i |
| ins_req_o | output | 1 | Insert request to the framer |
| oh_data_o | output | 1 | Overhead bit value to insert |
| slot_idx_o | output | 6 | Slot index of the most recent strobe |
| synced_o | output | 1 | High once a frame-aligned strobe has anchored the count |

## Verification
A slot counter that is off by one shows up at the ports on the very next strobe. The index differs, and the request appears on a neighbour of the intended position, carrying that neighbour's value bit. A sync flag that is stuck or lost shows up as requests while unsynced, or as silence after a frame-aligned strobe, both within one clock period. A request that lasts too long shows up one period after the strobe. The test sequences place masked and unmasked slots next to each other and give them differing values, so each of these faults changes an observed output.

// File: rtl/ds3oh_pkg.sv
package ds3oh_pkg;

  // Classification of what the framer presented at one falling edge.
  typedef enum logic [1:0] {
    EV_IDLE   = 2'd0,  // no strobe
    EV_ANCHOR = 2'd1,  // strobe together with the frame flag
    EV_STEP   = 2'd2,  // strobe alone
    EV_STRAY  = 2'd3   // frame flag without a strobe
  } strobe_ev_e;

  function automatic strobe_ev_e classify(input logic en, input logic frame);
    if (en && frame)  return EV_ANCHOR;
    if (en)           return EV_STEP;
    if (frame)        return EV_STRAY;
    return EV_IDLE;
  endfunction

  // True when the slot index is the final one of the multiframe.
  function automatic logic is_last_slot(input int unsigned idx, input int unsigned slots);
    return idx == slots - 1;
  endfunction

  // Index that follows idx; callers handle the wrap case separately.
  function automatic int unsigned slot_after(input int unsigned idx);
    return idx + 1;
  endfunction

  // True when an event consumes an overhead slot.
  function automatic logic is_strobe(input strobe_ev_e ev);
    return (ev == EV_ANCHOR) || (ev == EV_STEP);
  endfunction

endpackage

// File: rtl/ds3oh_strobe_decode.sv
module ds3oh_strobe_decode
  import ds3oh_pkg::*;
(
  input  logic       en_i,
  input  logic       frame_i,
  output strobe_ev_e ev_o
);

  always_comb ev_o = classify(en_i, frame_i);

endmodule

// File: rtl/ds3oh_slot_tracker.sv
module ds3oh_slot_tracker
  import ds3oh_pkg::*;
#(
  parameter int unsigned SLOTS = 56,
  localparam int unsigned POS_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_ev_e       ev_i,
  output logic [POS_W-1:0] pos_o,
  output logic             sync_o,
  output logic [POS_W-1:0] pos_nxt_o,
  output logic             sync_nxt_o
);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             sync_q, sync_d;

  // Named internal events for the checks below.
  logic at_last_w;
  logic wrap_w;
  logic step_w;

  always_comb at_last_w = is_last_slot(int'(pos_q), SLOTS);
  always_comb step_w    = (ev_i == EV_STEP) && sync_q && !at_last_w;
  always_comb wrap_w    = (ev_i == EV_STEP) && sync_q && at_last_w;

  always_comb begin
    pos_d  = pos_q;
    sync_d = sync_q;
    unique case (ev_i)
      EV_ANCHOR: begin
        pos_d  = '0;
        sync_d = 1'b1;
      end
      EV_STEP: begin
        if (wrap_w) begin
          pos_d  = '0;
          sync_d = 1'b0;
        end else if (step_w) begin
          pos_d = POS_W'(slot_after(int'(pos_q)));
        end
      end
      default: ;
    endcase
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      sync_q <= sync_d;
    end
  end

  assign pos_o      = pos_q;
  assign sync_o     = sync_q;
  assign pos_nxt_o  = pos_d;
  assign sync_nxt_o = sync_d;

  assert_anchor_R2: assert property (@(negedge clk) disable iff (rst)
    (ev_i == EV_ANCHOR) |=> (pos_q == '0) && sync_q);

  assert_advance_R3: assert property (@(negedge clk) disable iff (rst)
    step_w |=> (pos_q == $past(pos_q) + 1'b1) && sync_q);

  assert_unsynced_hold_R6: assert property (@(negedge clk) disable iff (rst)
    ((ev_i == EV_STEP) && !sync_q) |=> $stable(pos_q) && !sync_q);

  assert_wrap_drop_R7: assert property (@(negedge clk) disable iff (rst)
    wrap_w |=> !sync_q && (pos_q == '0));

  assert_stray_frame_R8: assert property (@(negedge clk) disable iff (rst)
    ((ev_i == EV_STRAY) || (ev_i == EV_IDLE)) |=> $stable(pos_q) && $stable(sync_q));

  assert_index_range_R3: assert property (@(negedge clk) disable iff (rst)
    int'(pos_q) < SLOTS);

endmodule

// File: rtl/ds3oh_insert_stage.sv
module ds3oh_insert_stage #(
  parameter int unsigned SLOTS = 56,
  localparam int unsigned POS_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [SLOTS-1:0] mask_i,
  input  logic [SLOTS-1:0] value_i,
  output logic             req_o,
  output logic             bit_o
);

  logic sel_mask_w;
  logic sel_value_w;
  logic take_w;

  always_comb begin
    sel_mask_w  = 1'b0;
    sel_value_w = 1'b0;
    if (int'(pos_i) < SLOTS) begin
      sel_mask_w  = mask_i[pos_i];
      sel_value_w = value_i[pos_i];
    end
  end

  always_comb take_w = fire_i && sel_mask_w;

  // The outputs are registered, so each decision holds for one full period.
  always_ff @(negedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
      bit_o <= 1'b0;
    end else begin
      req_o <= take_w;
      bit_o <= take_w & sel_value_w;
    end
  end

  assert_one_period_R4: assert property (@(negedge clk) disable iff (rst)
    !fire_i |=> !req_o);

  assert_value_carried_R5: assert property (@(negedge clk) disable iff (rst)
    take_w |=> req_o && (bit_o == $past(sel_value_w)));

  assert_quiet_data_R5: assert property (@(negedge clk) disable iff (rst)
    !req_o |-> !bit_o);

endmodule

// File: rtl/ds3oh_insert_ctrl.sv
module ds3oh_insert_ctrl
  import ds3oh_pkg::*;
#(
  parameter int unsigned SLOTS = 56,
  localparam int unsigned POS_W = $clog2(SLOTS)
) (
  input  logic             line_clk,
  input  logic             rst,
  input  logic             oh_en_i,
  input  logic             oh_frame_i,
  input  logic [SLOTS-1:0] ins_mask_i,
  input  logic [SLOTS-1:0] ins_value_i,
  output logic             ins_req_o,
  output logic             oh_data_o,
  output logic [POS_W-1:0] slot_idx_o,
  output logic             synced_o
);

  strobe_ev_e       ev_w;
  logic [POS_W-1:0] pos_nxt_w;
  logic             sync_nxt_w;
  logic             fire_w;

  ds3oh_strobe_decode u_decode (
    .en_i    (oh_en_i),
    .frame_i (oh_frame_i),
    .ev_o    (ev_w)
  );

  ds3oh_slot_tracker #(.SLOTS(SLOTS)) u_tracker (
    .clk        (line_clk),
    .rst        (rst),
    .ev_i       (ev_w),
    .pos_o      (slot_idx_o),
    .sync_o     (synced_o),
    .pos_nxt_o  (pos_nxt_w),
    .sync_nxt_o (sync_nxt_w)
  );

  // An overhead slot is served only if the strobe leaves the count anchored.
  always_comb fire_w = is_strobe(ev_w) && sync_nxt_w;

  ds3oh_insert_stage #(.SLOTS(SLOTS)) u_insert (
    .clk     (line_clk),
    .rst     (rst),
    .fire_i  (fire_w),
    .pos_i   (pos_nxt_w),
    .mask_i  (ins_mask_i),
    .value_i (ins_value_i),
    .req_o   (ins_req_o),
    .bit_o   (oh_data_o)
  );

  assert_no_request_unsynced_R6: assert property (@(negedge line_clk) disable iff (rst)
    !synced_o |-> !ins_req_o);

  assert_no_request_without_strobe_R4: assert property (@(negedge line_clk) disable iff (rst)
    !oh_en_i |=> !ins_req_o);

  assert_reanchor_R9: assert property (@(negedge line_clk) disable iff (rst)
    (oh_en_i && oh_frame_i && synced_o) |=> synced_o && (slot_idx_o == '0));

  assert_wrap_quiet_R7: assert property (@(negedge line_clk) disable iff (rst)
    (oh_en_i && !oh_frame_i && synced_o && (int'(slot_idx_o) == SLOTS - 1))
      |=> !ins_req_o && !synced_o);

endmodule

// File: tb/sim_ds3oh_insert_ctrl.sv
`timescale 1ns/1ps
module sim_ds3oh_insert_ctrl;

  localparam int CLK_PERIOD = 22;
  localparam int SLOTS      = 56;

  logic             line_clk = 1'b0;
  logic             rst      = 1'b1;
  logic             oh_en_i  = 1'b0;
  logic             oh_frame_i = 1'b0;
  logic [SLOTS-1:0] ins_mask_i  = 56'hC0_0000_0000_00A6;
  logic [SLOTS-1:0] ins_value_i = 56'h80_0000_0000_0084;
  logic             ins_req_o;
  logic             oh_data_o;
  logic [5:0]       slot_idx_o;
  logic             synced_o;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  always #(CLK_PERIOD/2) line_clk = ~line_clk;

  ds3oh_insert_ctrl u0 (
    .line_clk    (line_clk),
    .rst         (rst),
    .oh_en_i     (oh_en_i),
    .oh_frame_i  (oh_frame_i),
    .ins_mask_i  (ins_mask_i),
    .ins_value_i (ins_value_i),
    .ins_req_o   (ins_req_o),
    .oh_data_o   (oh_data_o),
    .slot_idx_o  (slot_idx_o),
    .synced_o    (synced_o)
  );

  // Row layout: {en, frame, exp_req, exp_bit, exp_idx[5:0], exp_sync}
  // Mask has slots 1,2,5,7,54,55 set; value has slots 2,7,55 set.
  localparam logic [10:0] VEC [16] = '{
    {1'b0,1'b0, 1'b0,1'b0, 6'd0, 1'b0},  // idle
    {1'b1,1'b0, 1'b0,1'b0, 6'd0, 1'b0},  // R6 strobe while unsynced
    {1'b0,1'b1, 1'b0,1'b0, 6'd0, 1'b0},  // R8 stray frame, unsynced
    {1'b1,1'b1, 1'b0,1'b0, 6'd0, 1'b1},  // R2 anchor, slot 0 unmasked
    {1'b0,1'b0, 1'b0,1'b0, 6'd0, 1'b1},  // idle
    {1'b1,1'b0, 1'b1,1'b0, 6'd1, 1'b1},  // R4 slot 1, value 0
    {1'b0,1'b0, 1'b0,1'b0, 6'd1, 1'b1},  // R4 request gone after one period
    {1'b1,1'b0, 1'b1,1'b1, 6'd2, 1'b1},  // R5 slot 2, value 1
    {1'b0,1'b1, 1'b0,1'b0, 6'd2, 1'b1},  // R8 stray frame while synced
    {1'b1,1'b0, 1'b0,1'b0, 6'd3, 1'b1},  // R3 unmasked slot
    {1'b1,1'b0, 1'b0,1'b0, 6'd4, 1'b1},  // R3 back to back
    {1'b1,1'b0, 1'b1,1'b0, 6'd5, 1'b1},  // R4 masked, value 0
    {1'b1,1'b0, 1'b0,1'b0, 6'd6, 1'b1},  // R4 unmasked after masked
    {1'b1,1'b0, 1'b1,1'b1, 6'd7, 1'b1},  // R5 masked, value 1
    {1'b1,1'b1, 1'b0,1'b0, 6'd0, 1'b1},  // R9 re-anchor at slot 7
    {1'b0,1'b0, 1'b0,1'b0, 6'd0, 1'b1}   // idle after re-anchor
  };

  task automatic step(input logic en, input logic fr);
    oh_en_i    = en;
    oh_frame_i = fr;
    @(posedge line_clk);
  endtask

  task automatic expect_out(input string req, input logic e_req, input logic e_bit,
                            input int e_idx, input logic e_sync);
    logic [8:0] got, exp;
    got = {ins_req_o, oh_data_o, slot_idx_o, synced_o};
    exp = {e_req, e_bit, 6'(e_idx), e_sync};
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual req=%b bit=%b idx=%0d sync=%b expected req=%b bit=%b idx=%0d sync=%b",
               req, got[8], got[7], got[6:1], got[0], exp[8], exp[7], exp[6:1], exp[0]);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 5000) #1;
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge line_clk);
    expect_out("R1 reset state", 1'b0, 1'b0, 0, 1'b0);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][10], VEC[i][9]);
      expect_out($sformatf("R2/R3/R4/R5/R6/R8/R9 row %0d", i),
                 VEC[i][8], VEC[i][7], int'(VEC[i][6:1]), VEC[i][0]);
    end

    // Walk to the end of the multiframe
    step(1'b1, 1'b1);
    expect_out("R2 anchor before long walk", 1'b0, 1'b0, 0, 1'b1);
    for (int k = 1; k <= 53; k++) step(1'b1, 1'b0);
    expect_out("R3 slot 53 after long walk", 1'b0, 1'b0, 53, 1'b1);
    step(1'b1, 1'b0);
    expect_out("R4 slot 54 masked value 0", 1'b1, 1'b0, 54, 1'b1);
    step(1'b1, 1'b0);
    expect_out("R5 slot 55 masked value 1", 1'b1, 1'b1, 55, 1'b1);
    step(1'b1, 1'b0);
    expect_out("R7 overrun past slot 55", 1'b0, 1'b0, 0, 1'b0);
    step(1'b1, 1'b0);
    expect_out("R6 strobe after sync loss", 1'b0, 1'b0, 0, 1'b0);
    step(1'b0, 1'b1);
    expect_out("R8 stray frame after sync loss", 1'b0, 1'b0, 0, 1'b0);

    // Recover and use a changed value vector
    step(1'b1, 1'b1);
    expect_out("R2 recovery anchor", 1'b0, 1'b0, 0, 1'b1);
    ins_value_i[1] = 1'b1;
    step(1'b1, 1'b0);
    expect_out("R5 slot 1 with updated value", 1'b1, 1'b1, 1, 1'b1);
    ins_mask_i[2] = 1'b0;
    step(1'b1, 1'b0);
    expect_out("R4 slot 2 unmasked by user", 1'b0, 1'b0, 2, 1'b1);

    // Reset in the middle of a frame
    rst = 1'b1;
    step(1'b1, 1'b0);
    expect_out("R1 reset mid frame", 1'b0, 1'b0, 0, 1'b0);
    rst = 1'b0;
    step(1'b0, 1'b0);
    expect_out("R1 idle after reset release", 1'b0, 1'b0, 0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule